// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device-side half of a receive DMA path. It walks a ring of receive descriptors in host memory and fills each one with one incoming Ethernet frame. A descriptor takes sixteen bytes: a status word, a control word that holds the buffer size and an end-of-ring flag, a buffer address, and a fourth word the block never reads. The host hands a descriptor to the device by setting the status ownership bit. The device then copies the frame into the buffer, writes back the final status with ownership cleared, and moves on to the next descriptor.

Frames arrive as a byte stream with valid/ready flow control. Each byte carries start, end and error flags. A byte moves across the stream port only in a cycle where both `in_valid` and `in_ready` are high. The block lowers `in_ready` in four cases:
- receive is disabled;
- a descriptor is being fetched;
- a packed buffer word is waiting for the memory port;
- the status write-back is pending.

The source must hold its byte and flags stable until the byte is accepted. Memory is reached through one word-wide request port with its own valid/ready handshake and a separate read-return strobe. If the current descriptor still belongs to the host, the block drains the frame, discards it and counts it as missed.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `in_ready` and `mem_valid` are low and `missed_frames` is zero. Receive starts disabled.
- R2: A register write to offset 0x18 loads the ring base address and rewinds the current descriptor to that base. A write to offset 0x30 sets the receive enable from data bit 1. While receive is disabled and idle, a byte flagged as frame start is not accepted (`in_ready` stays low).
- R3: For each frame the block reads the descriptor words at byte offsets +0 (status), +4 (control) and +8 (buffer address). It uses the descriptor only when status bit 31 is 1. The word at +12 is never used.
- R4: Frame byte k is stored at byte address buffer+k, little-endian within each 32-bit word. Byte enables cover only the bytes actually written.
- R5: The buffer size is control bits 10:0. Bytes beyond that size are not written, and their presence sets the error summary bit.
- R6: The status write-back has these fields:
  - bit 31 = 0 (ownership returned to the host);
  - bit 30 = 0;
  - bits 29:16 = the count of all frame bytes, including the trailing 4 CRC bytes;
  - bit 15 = 1 if any byte carried the error flag or the buffer overflowed;
  - bit 8 = 1 (last descriptor);
  - all other bits = 0.
- R7: After a write-back, the next descriptor is current address + 16. If control bit 25 is set, the next descriptor is the ring base instead.
- R8: If status bit 31 of the current descriptor is 0, the whole frame is accepted and dropped. Nothing is written, the descriptor index does not move, and `missed_frames` rises by one (saturating).
- R9: A byte without the start flag that arrives while the block is idle and enabled is accepted and discarded.
- R10: While `mem_valid` is high and `mem_ready` is low, the request (address, direction, data, enables) holds steady. At most one read is outstanding, and its data is taken on `mem_rvalid`.
- R11: No stream byte is accepted while a packed buffer word is waiting for the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted this cycle |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is first of a frame |
| in_eof | input | 1 | Byte is last of a frame |
| in_err | input | 1 | Byte carries a receive error |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |
| missed_frames | output | 16 | Frames dropped for lack of a device-owned descriptor |

## Verification
Two functions collide in the same cycle in this block. The first is the overflow cut-off, where the frame's last byte lands past the buffer size. The second is the flush of a partly filled final word, which must still be written out with its partial enables. A sweep of frame lengths against four buffer sizes provokes both, including the cases where the last written byte ends exactly on, or just before, a word boundary. The memory handshake is stalled on a fixed pattern throughout the sweep. Each frame is judged by comparing every byte of a pre-filled buffer region, and the written-back status word, against values the bench computes from the length, the size and the error flag.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FWAIT,
    ST_RECV,
    ST_WBACK,
    ST_DROP
  } rxr_state_e;

  localparam int OWN_BIT  = 31;
  localparam int EOR_BIT  = 25;
  localparam int ERRS_BIT = 15;
  localparam int LAST_BIT = 8;
  localparam int LEN_LSB  = 16;
  localparam int DESC_STRIDE = 16;

  localparam logic [7:0] OFS_RING_BASE = 8'h18;
  localparam logic [7:0] OFS_MODE      = 8'h30;
  localparam int MODE_RX_BIT = 1;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [AW-1:0] ring_base,
  output logic          rx_en,
  output logic          base_load
);
  import rxr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      rx_en     <= 1'b0;
      base_load <= 1'b0;
    end else begin
      base_load <= reg_wr && (reg_addr == OFS_RING_BASE);
      if (reg_wr && reg_addr == OFS_RING_BASE) ring_base <= reg_wdata[AW-1:0];
      if (reg_wr && reg_addr == OFS_MODE)      rx_en     <= reg_wdata[MODE_RX_BIT];
    end
  end
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack #(
  parameter int AW     = 32,
  parameter int SIZE_W = 11,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_fire,
  input  logic [7:0]        byte_in,
  input  logic              byte_err,
  input  logic              byte_last,
  input  logic [AW-1:0]     buf_base,
  input  logic [SIZE_W-1:0] buf_size,
  input  logic              wr_ack,
  output logic              wr_pend,
  output logic [AW-1:0]     wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  output logic              done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              frame_bad
);
  logic [SIZE_W-1:0] stored;
  logic [31:0]       acc, acc_n;
  logic [3:0]        be, be_n;
  logic [1:0]        lane;
  logic              fits, launch;
  logic [SIZE_W-1:0] word_ofs;

  assign lane     = stored[1:0];
  assign fits     = stored < buf_size;
  assign word_ofs = {stored[SIZE_W-1:2], 2'b00};

  always_comb begin
    acc_n = acc;
    be_n  = be;
    if (fits) begin
      acc_n[lane*8 +: 8] = byte_in;
      be_n[lane]         = 1'b1;
    end
    launch = byte_fire && ((fits && lane == 2'd3) || (byte_last && be_n != 4'b0000));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      stored    <= '0;
      acc       <= '0;
      be        <= '0;
      wr_pend   <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_be     <= '0;
      done      <= 1'b0;
      frame_len <= '0;
      frame_bad <= 1'b0;
    end else begin
      if (wr_ack) wr_pend <= 1'b0;
      if (byte_fire) begin
        frame_len <= frame_len + 1'b1;
        frame_bad <= frame_bad | byte_err | !fits;
        acc       <= acc_n;
        if (fits) stored <= stored + 1'b1;
        if (launch) begin
          wr_pend <= 1'b1;
          wr_data <= acc_n;
          wr_be   <= be_n;
          wr_addr <= buf_base + AW'(word_ofs);
          be      <= 4'b0000;
        end else begin
          be <= be_n;
        end
        if (byte_last) done <= 1'b1;
      end
    end
  end

  // R11
  no_byte_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |-> !wr_pend);

  // R5
  no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !start) |-> (stored <= buf_size));
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl #(
  parameter int AW     = 32,
  parameter int SIZE_W = 11,
  parameter int LEN_W  = 14,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [AW-1:0]     ring_base,
  input  logic              base_load,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              byte_fire,
  output logic              pk_start,
  output logic [AW-1:0]     buf_base,
  output logic [SIZE_W-1:0] buf_size,
  output logic              pk_ack,
  input  logic              pk_pend,
  input  logic [AW-1:0]     pk_addr,
  input  logic [31:0]       pk_data,
  input  logic [3:0]        pk_be,
  input  logic              pk_done,
  input  logic [LEN_W-1:0]  pk_len,
  input  logic              pk_bad,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] missed
);
  import rxr_pkg::*;

  rxr_state_e        st;
  logic [AW-1:0]     cur;
  logic [1:0]        fidx;
  logic              eor_q;
  logic [AW-3:0]     buf_q;
  logic [31:0]       sts_word;
  logic              drop_fire;

  assign buf_base = {buf_q, 2'b00};

  always_comb begin
    case (st)
      ST_IDLE: in_ready = rx_en && !in_sof;
      ST_DROP: in_ready = 1'b1;
      ST_RECV: in_ready = !pk_pend && !pk_done;
      default: in_ready = 1'b0;
    endcase
  end

  assign byte_fire = in_valid && in_ready && (st == ST_RECV);
  assign drop_fire = in_valid && in_ready && (st == ST_DROP);
  assign pk_start  = (st == ST_FWAIT) && mem_rvalid && (fidx == 2'd2);
  assign pk_ack    = (st == ST_RECV) && pk_pend && mem_ready;

  always_comb begin
    sts_word = '0;
    sts_word[LEN_LSB +: LEN_W] = pk_len;
    sts_word[ERRS_BIT] = pk_bad;
    sts_word[LAST_BIT] = 1'b1;
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    mem_be    = 4'hF;
    case (st)
      ST_FETCH: begin
        mem_valid = 1'b1;
        mem_addr  = cur + AW'({fidx, 2'b00});
      end
      ST_RECV: begin
        mem_valid = pk_pend;
        mem_we    = 1'b1;
        mem_addr  = pk_addr;
        mem_wdata = pk_data;
        mem_be    = pk_be;
      end
      ST_WBACK: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = sts_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur    <= '0;
      fidx   <= '0;
      eor_q  <= 1'b0;
      buf_q  <= '0;
      buf_size <= '0;
      missed <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (base_load) cur <= ring_base;
          else if (rx_en && in_valid && in_sof) begin
            st   <= ST_FETCH;
            fidx <= 2'd0;
          end
        end
        ST_FETCH: if (mem_ready) st <= ST_FWAIT;
        ST_FWAIT: if (mem_rvalid) begin
          case (fidx)
            2'd0: begin
              if (mem_rdata[OWN_BIT]) begin
                fidx <= 2'd1;
                st   <= ST_FETCH;
              end else begin
                if (missed != '1) missed <= missed + 1'b1;
                st <= ST_DROP;
              end
            end
            2'd1: begin
              buf_size <= mem_rdata[SIZE_W-1:0];
              eor_q    <= mem_rdata[EOR_BIT];
              fidx     <= 2'd2;
              st       <= ST_FETCH;
            end
            default: begin
              buf_q <= mem_rdata[AW-1:2];
              st    <= ST_RECV;
            end
          endcase
        end
        ST_RECV: if (pk_done && !pk_pend) st <= ST_WBACK;
        ST_WBACK: if (mem_ready) begin
          cur <= eor_q ? ring_base : cur + AW'(DESC_STRIDE);
          st  <= ST_IDLE;
        end
        ST_DROP: if (drop_fire && in_eof) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_be)));

  // R8
  missed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((missed == $past(missed)) || (missed == $past(missed) + 1'b1)));

  // R6
  wback_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WBACK) |-> (pk_done && !pk_pend));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW     = 32,
  parameter int SIZE_W = 11,
  parameter int LEN_W  = 14,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] missed_frames
);
  logic [AW-1:0]     ring_base, buf_base, pk_addr;
  logic              rx_en, base_load, byte_fire, pk_start, pk_ack;
  logic [SIZE_W-1:0] buf_size;
  logic              pk_pend, pk_done, pk_bad;
  logic [31:0]       pk_data;
  logic [3:0]        pk_be;
  logic [LEN_W-1:0]  pk_len;

  rxr_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ring_base(ring_base), .rx_en(rx_en),
    .base_load(base_load)
  );

  rxr_pack #(.AW(AW), .SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .start(pk_start), .byte_fire(byte_fire),
    .byte_in(in_data), .byte_err(in_err), .byte_last(in_eof),
    .buf_base(buf_base), .buf_size(buf_size), .wr_ack(pk_ack),
    .wr_pend(pk_pend), .wr_addr(pk_addr), .wr_data(pk_data), .wr_be(pk_be),
    .done(pk_done), .frame_len(pk_len), .frame_bad(pk_bad)
  );

  rxr_ctrl #(.AW(AW), .SIZE_W(SIZE_W), .LEN_W(LEN_W), .MISS_W(MISS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .base_load(base_load), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_ready(in_ready), .byte_fire(byte_fire),
    .pk_start(pk_start), .buf_base(buf_base), .buf_size(buf_size),
    .pk_ack(pk_ack), .pk_pend(pk_pend), .pk_addr(pk_addr),
    .pk_data(pk_data), .pk_be(pk_be), .pk_done(pk_done), .pk_len(pk_len),
    .pk_bad(pk_bad), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .missed(missed_frames)
  );
endmodule

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        mem_valid, mem_we, mem_ready, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;
  logic [15:0] missed_frames;

  logic [31:0] mem [0:1023];
  int unsigned cyc = 0;
  int vectors = 0, fails = 0;

  always #2.5 clk = ~clk;

  rx_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .missed_frames(missed_frames)
  );

  // memory model with a fixed stall pattern
  assign mem_ready = (cyc % 3) != 1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte(input int a);
    return mem[a >> 2][(a % 4) * 8 +: 8];
  endfunction

  function automatic logic [7:0] fbyte(input int seed, input int k);
    return 8'((seed * 7 + k * 13 + 1) & 255);
  endfunction

  task automatic regw(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic arm(input int dsc, input int size, input bit eor, input int bufa, input bit own);
    mem[dsc >> 2]       = own ? 32'h8000_0000 : 32'h0;
    mem[(dsc >> 2) + 1] = 32'(size) | (eor ? 32'h0200_0000 : 32'h0);
    mem[(dsc >> 2) + 2] = 32'(bufa);
    mem[(dsc >> 2) + 3] = 32'hDEAD_BEE0;
    for (int w = 0; w < 16; w++) mem[(bufa >> 2) + w] = 32'hEEEE_EEEE;
  endtask

  task automatic push(input logic [7:0] d, input bit s, input bit e, input bit er);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_err = er;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk); @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
  endtask

  task automatic send(input int len, input bit er, input int seed);
    for (int k = 0; k < len; k++)
      push(fbyte(seed, k), k == 0, k == len - 1, er && (k == len - 1));
  endtask

  task automatic wait_wb(input int dsc);
    for (int t = 0; t < 3000; t++) begin
      if (!mem[dsc >> 2][31]) break;
      @(negedge clk);
    end
  endtask

  // checks one finished frame: status word and a 16-byte buffer window
  task automatic judge(input int dsc, input int bufa, input int size, input int len,
                       input bit er, input int seed);
    logic [31:0] exp;
    int kept;
    bit bad;
    bad  = er || (len > size);
    kept = (len < size) ? len : size;
    exp  = (32'(len) << 16) | (bad ? 32'h8000 : 32'h0) | 32'h100;
    // R6 R5 R3
    chk(mem[dsc >> 2] == exp, "R6 status", mem[dsc >> 2], exp);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] eb;
      eb = (k < kept) ? fbyte(seed, k) : 8'hEE;
      // R4 byte placement, R5 bytes past size untouched
      chk(rbyte(bufa + k) == eb, (k < kept) ? "R4 data" : "R5 beyond size",
          32'(rbyte(bufa + k)), 32'(eb));
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b0, "R1 in_ready", 32'(in_ready), 0);
    chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
    chk(missed_frames == 0, "R1 missed", 32'(missed_frames), 0);

    regw(8'h18, 32'h100);
    regw(8'h30, 32'h2);

    // sweep: lengths against four buffer sizes, ring wraps via bit 25 (R7)
    for (int f = 0; f < 24; f++) begin
      int d, len;
      bit er;
      d   = f % 4;
      len = 1 + (f % 12);
      er  = (f % 5) == 3;
      arm(32'h100 + 16 * d, 5 + d, d == 3, 32'h400 + 32'h40 * d, 1'b1);
      send(len, er, f);
      wait_wb(32'h100 + 16 * d);
      // R7 R10 R11: frame lands in descriptor f%4 under memory stalls
      judge(32'h100 + 16 * d, 32'h400 + 32'h40 * d, 5 + d, len, er, f);
    end

    // R8: descriptor 0 still host-owned, frame is dropped
    arm(32'h100, 8, 1'b0, 32'h400, 1'b0);
    send(6, 1'b0, 77);
    repeat (6) @(negedge clk);
    chk(missed_frames == 1, "R8 missed count", 32'(missed_frames), 1);
    chk(mem[32'h100 >> 2] == 0, "R8 status untouched", mem[32'h100 >> 2], 0);
    chk(rbyte(32'h400) == 8'hEE, "R8 buffer untouched", 32'(rbyte(32'h400)), 32'hEE);
    arm(32'h100, 8, 1'b0, 32'h400, 1'b1);
    send(4, 1'b0, 78);
    wait_wb(32'h100);
    judge(32'h100, 32'h400, 8, 4, 1'b0, 78);  // R8 index held at descriptor 0

    // R9: stray byte without start flag while idle
    arm(32'h110, 8, 1'b0, 32'h440, 1'b1);
    push(8'h5A, 1'b0, 1'b0, 1'b0);
    send(3, 1'b0, 90);
    wait_wb(32'h110);
    judge(32'h110, 32'h440, 8, 3, 1'b0, 90);

    // R2: disabled receive does not take a start byte
    regw(8'h30, 32'h0);
    arm(32'h120, 8, 1'b0, 32'h480, 1'b1);
    in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h11;
    repeat (10) @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R2 disabled stall", 32'(in_ready), 0);
    chk(mem[32'h120 >> 2] == 32'h8000_0000, "R2 no fetch effect", mem[32'h120 >> 2], 32'h8000_0000);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    regw(8'h30, 32'h2);
    send(9, 1'b0, 91);
    wait_wb(32'h120);
    judge(32'h120, 32'h480, 8, 9, 1'b0, 91);

    // R2 R7: new base rewinds the index; single-entry ring wraps onto itself
    arm(32'h130, 8, 1'b1, 32'h4C0, 1'b1);
    regw(8'h18, 32'h200);
    for (int r = 0; r < 2; r++) begin
      arm(32'h200, 8, 1'b1, 32'h600, 1'b1);
      send(7 + r, 1'b0, 100 + r);
      wait_wb(32'h200);
      judge(32'h200, 32'h600, 8, 7 + r, 1'b0, 100 + r);
    end
    chk(mem[32'h130 >> 2] == 32'h8000_0000, "R2 old ring skipped", mem[32'h130 >> 2], 32'h8000_0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", vectors);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule